// File: doc/BRIEF.md
# Synchronous Byte Transmitter Abort Supervisor

This block sits between a framed byte source and the serializer of a byte-oriented synchronous line transmitter. It forwards bytes when the serializer asks for one. It also watches for two faults during a message. The first is an underrun: the serializer asks for a byte and the source has none. The second is loss of the clear-to-send line. Either fault stops the message at once. The block closes the buffer, sets a sticky status flag for the fault and can raise a transmit-error interrupt. It then refuses all traffic until a restart command arrives.

The source marks bytes with start-of-frame, end-of-frame and escape flags. The escape flag marks the first byte of a two-byte escape pair. A source may legally pause between frames or before the second byte of an escape pair, so an empty request at those points is not a fault. The restart command only releases the halt. The status flags stay set until a separate clear pulse.

Top module: `bsx_tx_guard`

## Requirements
- R1: A byte is transferred when `src_valid` and `src_ready` are both high. Its data appears on `ser_data` with `ser_valid` high for one cycle, in the cycle after the transfer, and bytes keep their order. `src_ready` equals `ser_req` AND synchronized CTS high AND (in a frame, or outside a frame with `src_sof`=1), and it is low while halted.
- R2: An underrun occurs inside a frame when `ser_req` is 1, `src_valid` is 0 and no escape pair is open. In the next cycle `flag_un`=1, `buf_close` is high for exactly one cycle and `tx_halted`=1.
- R3: On any abort, `tx_err_irq` is high for exactly one cycle, the cycle after the abort, only if `irq_en` was 1 in the abort cycle. Otherwise it stays 0.
- R4: While halted, `src_ready` is 0 and nothing is forwarded. A `restart` pulse returns the block to idle in the next cycle and leaves `flag_un` and `flag_ct` unchanged.
- R5: Outside a frame (idle gap), `ser_req`=1 with `src_valid`=0 never sets `flag_un` or halts the block.
- R6: After a byte with `src_esc`=1 (and `src_eof`=0) is transferred, requests with no data do not cause an underrun until the next byte is transferred.
- R7: `cts` passes through CTS_SYNC flip-flops. If the synchronized value is 0 while in a frame, the next cycle shows `flag_ct`=1, a one-cycle `buf_close` and `tx_halted`=1, with the interrupt governed by R3.
- R8: If a CTS loss and an underrun are detected in the same cycle, `flag_ct` is set and `flag_un` is not.
- R9: A `stat_clr` pulse clears both flags in the next cycle. An abort detected in the same cycle still sets its flag.
- R10: A low `cts` outside a frame forwards nothing, sets no flag and does not halt.
- R11: Transferring a byte with `src_eof`=1 gives one `buf_close` pulse in the next cycle, sets no flag and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_valid | input | 1 | Source has a byte |
| src_ready | output | 1 | Block takes the byte this cycle |
| src_data | input | DATA_W | Source byte |
| src_sof | input | 1 | Byte opens a frame |
| src_eof | input | 1 | Byte ends the frame |
| src_esc | input | 1 | Byte is the first of an escape pair |
| ser_req | input | 1 | Serializer asks for the next byte |
| ser_valid | output | 1 | Byte presented to the serializer |
| ser_data | output | DATA_W | Byte to the serializer |
| cts | input | 1 | Clear-to-send, asynchronous |
| irq_en | input | 1 | Transmit-error interrupt enable |
| restart | input | 1 | Restart-transmit command pulse |
| stat_clr | input | 1 | Status flag clear pulse |
| buf_close | output | 1 | Buffer closed (end of frame or abort) |
| flag_un | output | 1 | Sticky underrun flag |
| flag_ct | output | 1 | Sticky CTS-lost flag |
| tx_err_irq | output | 1 | Transmit-error interrupt pulse |
| tx_halted | output | 1 | Waiting for restart |

## Verification
The bench builds the block with DATA_W=8 and CTS_SYNC=2. With two synchronizer stages the bench knows exactly when a falling `cts` takes effect. It lowers `cts`, waits two cycles, then issues an empty `ser_req`, so the CTS loss and the underrun land in the same detection cycle. That ties the priority rule R8 to a known cycle. Eight-bit data lets the scoreboard compare distinct byte values across normal frames, escape pairs and recovery frames after restart.

// File: rtl/bsx_pkg.sv
package bsx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_HALT = 2'd2
    } bsx_state_e;

    typedef struct packed {
        bsx_state_e state;
        logic       esc_pend;
        logic       flag_un;
        logic       flag_ct;
        logic       irq;
        logic       close;
    } bsx_seq_t;

endpackage

// File: rtl/bsx_cts_sync.sv
module bsx_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_in,
    output logic cts_ok
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign cts_ok = cts_in;
        end else begin : g_chain
            logic [STAGES-1:0] sync_d, sync_q;

            always_comb begin
                sync_d = {sync_q[STAGES-1:0], cts_in} >> 1;
                sync_d[STAGES-1] = cts_in;
                if (STAGES > 1) begin
                    sync_d = {cts_in, sync_q[STAGES-1:1]};
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= sync_d;
            end

            assign cts_ok = sync_q[0];
        end
    endgenerate

endmodule

// File: rtl/bsx_fault_detect.sv
module bsx_fault_detect
    import bsx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bsx_state_e state,
    input  logic       esc_pend,
    input  logic       ser_req,
    input  logic       src_valid,
    input  logic       cts_ok,
    output logic       un_hit,
    output logic       ct_hit
);

    logic in_frame;
    logic starved;

    always_comb begin
        in_frame = (state == ST_SEND);
        starved  = ser_req && !src_valid && !esc_pend;
        ct_hit   = in_frame && !cts_ok;
        // clear-to-send loss outranks a simultaneous underrun
        un_hit   = in_frame && starved && !ct_hit;
    end

    p_no_un_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SEND) |-> !un_hit);

    p_no_un_esc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        esc_pend |-> !un_hit);

    p_ct_over_un_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ct_hit |-> !un_hit);

endmodule

// File: rtl/bsx_out_stage.sv
module bsx_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic              dout_valid,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = take;
        if (take) out_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dout_valid = out_q.vld;
    assign dout       = out_q.data;

    p_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (dout_valid && dout == $past(din)));

endmodule

// File: rtl/bsx_seq.sv
module bsx_seq
    import bsx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_req,
    input  logic       src_valid,
    input  logic       src_sof,
    input  logic       src_eof,
    input  logic       src_esc,
    input  logic       cts_ok,
    input  logic       un_hit,
    input  logic       ct_hit,
    input  logic       irq_en,
    input  logic       restart,
    input  logic       stat_clr,
    output logic       src_ready,
    output logic       take,
    output bsx_state_e state,
    output logic       esc_pend,
    output logic       flag_un,
    output logic       flag_ct,
    output logic       irq,
    output logic       close
);

    bsx_seq_t seq_d, seq_q;
    logic     abort;

    always_comb begin
        case (seq_q.state)
            ST_SEND: src_ready = ser_req && cts_ok;
            ST_IDLE: src_ready = ser_req && cts_ok && src_sof;
            default: src_ready = 1'b0;
        endcase
        take  = src_valid && src_ready;
        abort = un_hit || ct_hit;
    end

    always_comb begin
        seq_d       = seq_q;
        seq_d.irq   = 1'b0;
        seq_d.close = 1'b0;
        if (stat_clr) begin
            seq_d.flag_un = 1'b0;
            seq_d.flag_ct = 1'b0;
        end
        case (seq_q.state)
            ST_IDLE: begin
                if (take) begin
                    seq_d.esc_pend = src_esc && !src_eof;
                    seq_d.close    = src_eof;
                    seq_d.state    = src_eof ? ST_IDLE : ST_SEND;
                end
            end
            ST_SEND: begin
                if (abort) begin
                    seq_d.state    = ST_HALT;
                    seq_d.close    = 1'b1;
                    seq_d.irq      = irq_en;
                    seq_d.esc_pend = 1'b0;
                    if (ct_hit) seq_d.flag_ct = 1'b1;
                    else        seq_d.flag_un = 1'b1;
                end else if (take) begin
                    seq_d.esc_pend = src_esc && !src_eof;
                    if (src_eof) begin
                        seq_d.state = ST_IDLE;
                        seq_d.close = 1'b1;
                    end
                end
            end
            default: begin
                if (restart) seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state    = seq_q.state;
    assign esc_pend = seq_q.esc_pend;
    assign flag_un  = seq_q.flag_un;
    assign flag_ct  = seq_q.flag_ct;
    assign irq      = seq_q.irq;
    assign close    = seq_q.close;

    p_un_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        un_hit |=> (flag_un && close && state == ST_HALT));

    p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en && (un_hit || ct_hit)));

    p_halt_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> !src_ready);

    p_restart_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && restart && !stat_clr) |=>
            (state == ST_IDLE && $stable(flag_un) && $stable(flag_ct)));

    p_ct_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ct_hit |=> (flag_ct && close && state == ST_HALT));

    p_ct_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_hit && !flag_un) |=> !flag_un);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !un_hit && !ct_hit) |=> (!flag_un && !flag_ct));

endmodule

// File: rtl/bsx_tx_guard.sv
module bsx_tx_guard
    import bsx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CTS_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_sof,
    input  logic              src_eof,
    input  logic              src_esc,
    input  logic              ser_req,
    output logic              ser_valid,
    output logic [DATA_W-1:0] ser_data,
    input  logic              cts,
    input  logic              irq_en,
    input  logic              restart,
    input  logic              stat_clr,
    output logic              buf_close,
    output logic              flag_un,
    output logic              flag_ct,
    output logic              tx_err_irq,
    output logic              tx_halted
);

    logic       cts_ok;
    logic       un_hit, ct_hit;
    logic       take;
    logic       esc_pend;
    bsx_state_e state;

    bsx_cts_sync #(.STAGES(CTS_SYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cts_in (cts),
        .cts_ok (cts_ok)
    );

    bsx_fault_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .esc_pend  (esc_pend),
        .ser_req   (ser_req),
        .src_valid (src_valid),
        .cts_ok    (cts_ok),
        .un_hit    (un_hit),
        .ct_hit    (ct_hit)
    );

    bsx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_req   (ser_req),
        .src_valid (src_valid),
        .src_sof   (src_sof),
        .src_eof   (src_eof),
        .src_esc   (src_esc),
        .cts_ok    (cts_ok),
        .un_hit    (un_hit),
        .ct_hit    (ct_hit),
        .irq_en    (irq_en),
        .restart   (restart),
        .stat_clr  (stat_clr),
        .src_ready (src_ready),
        .take      (take),
        .state     (state),
        .esc_pend  (esc_pend),
        .flag_un   (flag_un),
        .flag_ct   (flag_ct),
        .irq       (tx_err_irq),
        .close     (buf_close)
    );

    bsx_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .din        (src_data),
        .dout_valid (ser_valid),
        .dout       (ser_data)
    );

    assign tx_halted = (state == ST_HALT);

    p_idle_cts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cts_ok) |=> (!ser_valid && state == ST_IDLE));

    p_eof_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && src_eof) |=> (buf_close && state == ST_IDLE));

endmodule

// File: tb/tb_bsx_tx_guard.sv
module tb_bsx_tx_guard;

    localparam int DATA_W   = 8;
    localparam int CTS_SYNC = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic src_valid, src_ready, src_sof, src_eof, src_esc, ser_req;
    logic [DATA_W-1:0] src_data, ser_data;
    logic ser_valid, cts, irq_en, restart, stat_clr;
    logic buf_close, flag_un, flag_ct, tx_err_irq, tx_halted;

    int total = 0;
    int bad   = 0;
    logic [DATA_W-1:0] exp_q[$];

    always #5 clk = ~clk;

    bsx_tx_guard #(.DATA_W(DATA_W), .CTS_SYNC(CTS_SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
        .src_data(src_data), .src_sof(src_sof), .src_eof(src_eof), .src_esc(src_esc),
        .ser_req(ser_req), .ser_valid(ser_valid), .ser_data(ser_data), .cts(cts),
        .irq_en(irq_en), .restart(restart), .stat_clr(stat_clr), .buf_close(buf_close),
        .flag_un(flag_un), .flag_ct(flag_ct), .tx_err_irq(tx_err_irq), .tx_halted(tx_halted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every byte reaching the serializer is popped and compared (R1)
    always @(negedge clk) begin
        if (rst_n && ser_valid) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R1: actual=%0h expected=none", ser_data);
            end else begin
                chk("R1 byte order", ser_data, exp_q.pop_front());
            end
        end
    end

    task automatic idle_in();
        src_valid = 0; ser_req = 0; src_sof = 0; src_eof = 0; src_esc = 0; src_data = '0;
    endtask

    // offer one byte with a request; returns at the negedge where results show
    task automatic push_byte(input logic [DATA_W-1:0] d, input logic s, input logic e,
                             input logic x);
        src_data = d; src_sof = s; src_eof = e; src_esc = x;
        src_valid = 1; ser_req = 1;
        exp_q.push_back(d);
        @(negedge clk);
        idle_in();
    endtask

    task automatic empty_req();
        ser_req = 1; src_valid = 0;
        @(negedge clk);
        ser_req = 0;
    endtask

    task automatic do_restart();
        restart = 1;
        @(negedge clk);
        restart = 0;
    endtask

    task automatic do_clear();
        stat_clr = 1;
        @(negedge clk);
        stat_clr = 0;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; cts = 1; irq_en = 1; restart = 0; stat_clr = 0;
        idle_in();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2 reset flag_un", flag_un, 0);
        chk("R7 reset flag_ct", flag_ct, 0);
        chk("R4 reset halted", tx_halted, 0);
        chk("R3 reset irq", tx_err_irq, 0);
        chk("R1 reset ser_valid", ser_valid, 0);
        repeat (CTS_SYNC + 2) @(negedge clk);

        // R1 / R11: normal frame with quiet gaps
        push_byte(8'hA1, 1, 0, 0);
        repeat (2) @(negedge clk);
        push_byte(8'hA2, 0, 0, 0);
        push_byte(8'hA3, 0, 1, 0);
        chk("R11 close on eof", buf_close, 1);
        chk("R11 no flag_un", flag_un, 0);
        @(negedge clk);
        chk("R11 close one pulse", buf_close, 0);
        chk("R11 back to idle", tx_halted, 0);

        // R5: empty requests between frames
        repeat (5) empty_req();
        chk("R5 no underrun in gap", flag_un, 0);
        chk("R5 not halted in gap", tx_halted, 0);

        // R6: pause inside escape pair
        push_byte(8'hB1, 1, 0, 0);
        push_byte(8'h10, 0, 0, 1);
        repeat (3) empty_req();
        chk("R6 no underrun in pair", flag_un, 0);
        chk("R6 not halted in pair", tx_halted, 0);
        push_byte(8'hB3, 0, 0, 0);
        push_byte(8'hB4, 0, 1, 0);
        chk("R6 frame closes", buf_close, 1);

        // R2 / R3: underrun with interrupt enabled
        push_byte(8'hC1, 1, 0, 0);
        empty_req();
        chk("R2 flag_un set", flag_un, 1);
        chk("R2 close on underrun", buf_close, 1);
        chk("R2 halted", tx_halted, 1);
        chk("R3 irq raised", tx_err_irq, 1);
        @(negedge clk);
        chk("R3 irq one pulse", tx_err_irq, 0);

        // R4: halted blocks traffic; restart keeps flags
        src_data = 8'hEE; src_sof = 1; src_valid = 1; ser_req = 1;
        #1;
        chk("R4 ready low halted", src_ready, 0);
        repeat (3) @(negedge clk);
        idle_in();
        chk("R4 still halted", tx_halted, 1);
        do_restart();
        chk("R4 restart releases", tx_halted, 0);
        chk("R4 flag kept", flag_un, 1);
        do_clear();
        chk("R9 flag_un cleared", flag_un, 0);

        // R3: underrun with interrupt disabled
        irq_en = 0;
        push_byte(8'hC2, 1, 0, 0);
        empty_req();
        chk("R3 flag_un set masked", flag_un, 1);
        chk("R3 irq masked", tx_err_irq, 0);
        irq_en = 1;
        do_restart();
        do_clear();

        // R7: CTS drops mid-frame
        push_byte(8'hD1, 1, 0, 0);
        push_byte(8'hD2, 0, 0, 0);
        cts = 0;
        repeat (CTS_SYNC + 1) @(negedge clk);
        chk("R7 flag_ct set", flag_ct, 1);
        chk("R7 close", buf_close, 1);
        chk("R7 halted", tx_halted, 1);
        chk("R7 irq", tx_err_irq, 1);
        chk("R7 no flag_un", flag_un, 0);
        do_restart();
        do_clear();
        chk("R9 flag_ct cleared", flag_ct, 0);

        // R10: CTS low outside a frame
        src_data = 8'h55; src_sof = 1; src_valid = 1; ser_req = 1;
        #1;
        chk("R10 ready low without cts", src_ready, 0);
        repeat (3) @(negedge clk);
        idle_in();
        chk("R10 no flag_ct", flag_ct, 0);
        chk("R10 not halted", tx_halted, 0);
        cts = 1;
        repeat (CTS_SYNC + 1) @(negedge clk);

        // R8: CTS loss and underrun in the same detection cycle
        push_byte(8'hE1, 1, 0, 0);
        cts = 0;
        repeat (CTS_SYNC) @(negedge clk);
        empty_req();
        chk("R8 flag_ct set", flag_ct, 1);
        chk("R8 flag_un not set", flag_un, 0);
        cts = 1;
        do_restart();
        do_clear();
        repeat (CTS_SYNC + 1) @(negedge clk);

        // recovery frame after aborts
        push_byte(8'hF1, 1, 0, 0);
        push_byte(8'hF2, 0, 1, 0);
        chk("R11 recovery close", buf_close, 1);
        repeat (3) @(negedge clk);
        chk("R1 all bytes seen", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule